// File: doc/BRIEF.md
# Sortable Shift-Register LIFO Stack

This block is a last-in-first-out store built from a chain of word registers that shift toward or away from the top. A push moves every stored word one place deeper and writes the new word at the top. A pop moves every stored word one place back toward the top. A saturating occupancy counter tracks how many words are held and drives the empty and full flags.

On request, the stack sorts the words it holds, in place. While it sorts, incoming push and pop requests have no effect. The sorter runs bubble-sort passes over the valid words only, and it swaps one neighbouring pair per cycle at most. Each pair has its own small comparator that drives the existing per-register shift controls: the upper register of the pair shifts from below and the lower register shifts from above, so the two words trade places.

A decoder selects one comparator at a time, driven by a down-counting pair index. When the last pass is complete, a single-cycle done pulse is raised and normal operation resumes.

Top module: `sortstk_top`

## Requirements
- R1: A push into a non-full stack makes the pushed word visible on `top_o` after the next clock edge. The occupancy count rises by one, and earlier words keep their LIFO order below it.
- R2: A pop from a non-empty stack removes the top word. The next older word appears on `top_o`, and the count falls by one.
- R3: After reset the count is 0, `empty_o` is 1, `full_o` is 0 and `top_o` is 0. A pop while empty leaves the count at 0 and `empty_o` at 1.
- R4: With `DEPTH` words held, `full_o` is 1. A push while full leaves the count at `DEPTH` and leaves every stored word unchanged.
- R5: A cycle with push and pop both requested in normal mode changes neither the count nor the contents.
- R6: While a sort request is being taken and while the sort runs, push and pop requests are ignored. The occupancy count stays constant throughout.
- R7: With `sort_asc_i` = 1, after the done pulse the words are ordered by unsigned value with the smallest at the top. Successive pops therefore return a non-decreasing sequence holding exactly the words that were stored.
- R8: With `sort_asc_i` = 0, after the done pulse the words are ordered by unsigned value with the largest at the top. Successive pops therefore return a non-increasing sequence.
- R9: A sort touches only the words currently held. After the sort, popping exactly count words empties the stack.
- R10: A sort request with fewer than two words held raises `sort_done_o` in the first cycle after the request edge. The held word, if there is one, is unchanged.
- R11: Every sort request produces exactly one `sort_done_o` pulse, and the pulse is one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push request (normal mode) |
| pop_i | input | 1 | Pop request (normal mode) |
| din_i | input | WIDTH | Word to push |
| sort_start_i | input | 1 | Request a sort of the held words |
| sort_asc_i | input | 1 | 1 = smallest at top, 0 = largest at top; held until done |
| top_o | output | WIDTH | Word at the top of the stack |
| count_o | output | $clog2(DEPTH+1) | Number of words held |
| empty_o | output | 1 | No words held |
| full_o | output | 1 | DEPTH words held |
| sort_done_o | output | 1 | One-cycle pulse at end of sort |

## Verification
The bench builds the stack with DEPTH = 6 and WIDTH = 8. At that depth the full boundary and a complete multi-pass sort of a full stack are reached in a few dozen cycles. The 8-bit words include values with the top bit set and repeated values, which exercise the unsigned comparison and the handling of equal neighbours. Partial fills of four, one and zero words cover the sort bound to the count and the early-exit path.

// File: rtl/sortstk_pkg.sv
`timescale 1ns/1ps
// Shared types for the sortable stack: sequencer state encoding.
package sortstk_pkg;

    // Sort sequencer states: idle, start of pass, compare pair, step index
    typedef enum logic [1:0] {
        SS_IDLE = 2'b00,
        SS_PASS = 2'b01,
        SS_CMP  = 2'b10,
        SS_STEP = 2'b11
    } sort_state_e;

endpackage

// File: rtl/sortstk_cell.sv
`timescale 1ns/1ps
// One word register of the stack chain.
// Loads from the neighbour above on shift_dn, from the neighbour below on shift_up.
// Assumes the two shift controls are never active together.
module sortstk_cell #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_dn,
    input  logic             shift_up,
    input  logic [WIDTH-1:0] from_above,
    input  logic [WIDTH-1:0] from_below,
    output logic [WIDTH-1:0] q
);

    // Word storage: take the word from above or below, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_dn) q <= from_above;
        else if (shift_up) q <= from_below;
    end

    AST_ONE_SHIFT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_dn && shift_up)); // R5

endmodule

// File: rtl/sortstk_xchg.sv
`timescale 1ns/1ps
// Pair exchanger: flags that two neighbouring words must trade places.
// The upper word is nearer the top. Comparison is unsigned.
// Assumes at most one exchanger is enabled per cycle.
module sortstk_xchg #(
    parameter int WIDTH = 8
) (
    input  logic             en,
    input  logic             asc,
    input  logic [WIDTH-1:0] upper,
    input  logic [WIDTH-1:0] lower,
    output logic             swap
);

    // Out-of-order test for the selected ordering
    always_comb begin
        if (asc) swap = en && (upper > lower);
        else     swap = en && (upper < lower);
    end

endmodule

// File: rtl/sortstk_occ.sv
`timescale 1ns/1ps
// Saturating occupancy counter with empty and full flags.
// Assumes inc and dec are already qualified by the caller (never both, no overflow).
module sortstk_occ #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    // Count register: up on push, down on pop, reload otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
        else if (dec) count <= count - 1'b1;
        else          count <= count;
    end

    // Status flags from the count
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end

endmodule

// File: rtl/sortstk_ctrl.sv
`timescale 1ns/1ps
// Bubble-sort sequencer.
// The pass counter i rises from 0. Each pass walks the pair index j down from count-2 to i.
// One compare-and-maybe-swap cycle is followed by one index-step cycle.
// A request with fewer than two words ends at once.
// Assumes count is frozen while busy (the top masks push and pop).
module sortstk_ctrl #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int JW    = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             sel_en,
    output logic [CNT_W-1:0] sel_idx,
    output logic             done
);
    import sortstk_pkg::*;

    sort_state_e      state;
    logic [CNT_W-1:0] pass_i;
    logic [JW-1:0]    pair_j;
    logic [JW-1:0]    last_pair;
    logic             more_passes;
    logic             more_pairs;

    // Loop conditions; guarded so count-2 never wraps
    always_comb begin
        last_pair   = {1'b0, count} - JW'(2);
        more_passes = (count >= CNT_W'(2)) && ({1'b0, pass_i} <= last_pair);
        more_pairs  = !pair_j[JW-1] && (pair_j[CNT_W-1:0] >= pass_i);
    end

    // State register and the two loop counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SS_IDLE;
            pass_i <= '0;
            pair_j <= '0;
        end else begin
            case (state)
                SS_IDLE: if (start) begin
                    pass_i <= '0;
                    state  <= SS_PASS;
                end
                SS_PASS: if (more_passes) begin
                    pair_j <= last_pair;
                    state  <= SS_CMP;
                end else begin
                    state  <= SS_IDLE;
                end
                SS_CMP: if (more_pairs) begin
                    state  <= SS_STEP;
                end else begin
                    pass_i <= pass_i + 1'b1;
                    state  <= SS_PASS;
                end
                default: begin
                    pair_j <= pair_j - 1'b1;
                    state  <= SS_CMP;
                end
            endcase
        end
    end

    // Control outputs decoded from state and conditions
    always_comb begin
        busy    = (state != SS_IDLE);
        sel_en  = (state == SS_CMP) && more_pairs;
        sel_idx = pair_j[CNT_W-1:0];
        done    = (state == SS_PASS) && !more_passes;
    end

    AST_SHORT_SORT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_IDLE && start && count < CNT_W'(2)) |=> done); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

endmodule

// File: rtl/sortstk_top.sv
`timescale 1ns/1ps
// Sortable LIFO stack: a chain of DEPTH word registers with per-pair exchangers.
// Index 0 is the top. Push and pop shift the whole chain.
// A sort reuses the same shift controls to swap one neighbouring pair per cycle.
// Assumes sort_asc_i is held steady from the sort request until sort_done_o.
module sortstk_top #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [WIDTH-1:0]           din_i,
    input  logic                       sort_start_i,
    input  logic                       sort_asc_i,
    output logic [WIDTH-1:0]           top_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic                       sort_done_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NPAIR = DEPTH - 1;

    logic [WIDTH-1:0] word   [DEPTH];
    logic [DEPTH-1:0] sh_dn;
    logic [DEPTH-1:0] sh_up;
    logic [NPAIR-1:0] pair_en;
    logic [NPAIR-1:0] pair_swap;
    logic             busy;
    logic             sel_en;
    logic [CNT_W-1:0] sel_idx;
    logic             blocked;
    logic             do_push;
    logic             do_pop;

    // Qualify external requests: masked by sorting, by each other, and by the flags
    always_comb begin
        blocked = busy || sort_start_i;
        do_push = push_i && !pop_i && !blocked && !full_o;
        do_pop  = pop_i && !push_i && !blocked && !empty_o;
    end

    sortstk_occ #(.DEPTH(DEPTH)) occ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (do_push),
        .dec   (do_pop),
        .count (count_o),
        .empty (empty_o),
        .full  (full_o)
    );

    sortstk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sort_start_i && !busy),
        .count   (count_o),
        .busy    (busy),
        .sel_en  (sel_en),
        .sel_idx (sel_idx),
        .done    (sort_done_o)
    );

    // One exchanger per neighbouring pair, enabled through the index decoder
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_en[p] = sel_en && (sel_idx == CNT_W'(p));
        sortstk_xchg #(.WIDTH(WIDTH)) xchg_i (
            .en    (pair_en[p]),
            .asc   (sort_asc_i),
            .upper (word[p]),
            .lower (word[p+1]),
            .swap  (pair_swap[p])
        );
    end

    // Register chain: shift controls merge external requests and pair swaps
    for (genvar k = 0; k < DEPTH; k++) begin : g_cell
        logic [WIDTH-1:0] above;
        logic [WIDTH-1:0] below;
        if (k == 0) begin : g_head
            assign above    = din_i;
            assign sh_dn[k] = do_push;
        end else begin : g_body
            assign above    = word[k-1];
            assign sh_dn[k] = do_push || pair_swap[k-1];
        end
        if (k == DEPTH - 1) begin : g_tail
            assign below    = '0;
            assign sh_up[k] = do_pop;
        end else begin : g_inner
            assign below    = word[k+1];
            assign sh_up[k] = do_pop || pair_swap[k];
        end
        sortstk_cell #(.WIDTH(WIDTH)) cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .shift_dn   (sh_dn[k]),
            .shift_up   (sh_up[k]),
            .from_above (above),
            .from_below (below),
            .q          (word[k])
        );
    end

    assign top_o = word[0];

    AST_POP_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !blocked && empty_o) |=> (empty_o && count_o == '0)); // R3

    AST_PUSH_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !blocked && full_o) |=> (count_o == CNT_W'(DEPTH))); // R4

    AST_COUNT_FROZEN_SORT: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> $stable(count_o)); // R6

    AST_ONE_PAIR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pair_en)); // R7

endmodule

// File: tb/sortstk_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: a model queue (index 0 = top) tracks expected contents.
// Drain compares each popped word against the queue front.
module sortstk_top_tb_top;
    localparam int DEPTH = 6;
    localparam int WIDTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] din_i = '0;
    logic             sort_start_i = 1'b0;
    logic             sort_asc_i = 1'b0;
    logic [WIDTH-1:0] top_o;
    logic [CW-1:0]    count_o;
    logic             empty_o;
    logic             full_o;
    logic             sort_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int model[$];

    always #2.5 clk = ~clk;

    sortstk_top #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
        .sort_start_i(sort_start_i), .sort_asc_i(sort_asc_i), .top_o(top_o),
        .count_o(count_o), .empty_o(empty_o), .full_o(full_o), .sort_done_o(sort_done_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One clock of stimulus; inputs change 1 ns after the edge; the model follows
    task automatic op(input bit pu, input bit po, input int d);
        push_i = pu; pop_i = po; din_i = WIDTH'(d);
        @(posedge clk); #1;
        push_i = 0; pop_i = 0;
        if (pu && !po && model.size() < DEPTH) model.push_front(d);
        else if (po && !pu && model.size() > 0) void'(model.pop_front());
    endtask

    // Monitor side: pop everything, compare each top with the model front
    task automatic drain(input string tag);
        int n = model.size();
        for (int k = 0; k < n; k++) begin
            chk(tag, int'(top_o), model[0]);
            op(0, 1, 0);
        end
        chk({tag, " empty after count pops (R9)"}, int'(empty_o), 1);
    endtask

    // Request a sort, hold pop high while it runs, count done pulses
    task automatic run_sort(input bit asc, input string tag, output int latency);
        int dones = 0;
        int held = model.size();
        latency = -1;
        sort_asc_i = asc; sort_start_i = 1; pop_i = 1;
        @(posedge clk); #1;
        sort_start_i = 0;
        for (int c = 0; c < 1000; c++) begin
            if (sort_done_o) begin dones++; latency = c; break; end
            chk({tag, " count frozen during sort (R6)"}, int'(count_o), held);
            @(posedge clk); #1;
        end
        pop_i = 0;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            if (sort_done_o) dones++;
        end
        chk({tag, " single done pulse (R11)"}, dones, 1);
        chk({tag, " count after sort (R6)"}, int'(count_o), held);
        if (asc) model.sort(); else model.rsort();
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("R3 reset count", int'(count_o), 0);
        chk("R3 reset empty", int'(empty_o), 1);
        chk("R3 reset full", int'(full_o), 0);
        chk("R3 reset top", int'(top_o), 0);
        chk("R11 reset done low", int'(sort_done_o), 0);

        op(1, 0, 8'h21); chk("R1 top after push", int'(top_o), 8'h21);
        op(1, 0, 8'h9C); chk("R1 top after push", int'(top_o), 8'h9C);
        op(1, 0, 8'h47); chk("R1 top after push", int'(top_o), 8'h47);
        chk("R1 count", int'(count_o), 3);

        op(1, 1, 8'hEE);
        chk("R5 count on push+pop", int'(count_o), 3);
        chk("R5 top on push+pop", int'(top_o), 8'h47);

        op(0, 1, 0);
        chk("R2 top after pop", int'(top_o), 8'h9C);
        chk("R2 count after pop", int'(count_o), 2);
        drain("R2 LIFO order");
        op(0, 1, 0);
        chk("R3 pop on empty count", int'(count_o), 0);
        chk("R3 pop on empty flag", int'(empty_o), 1);

        op(1, 0, 8'h80); op(1, 0, 8'h05); op(1, 0, 8'hFF);
        op(1, 0, 8'h05); op(1, 0, 8'h7F); op(1, 0, 8'h00);
        chk("R4 full flag", int'(full_o), 1);
        op(1, 0, 8'hAA);
        chk("R4 push on full count", int'(count_o), DEPTH);
        chk("R4 push on full top", int'(top_o), 8'h00);

        run_sort(1'b1, "R7 ascending full", lat);
        drain("R7 ascending order");

        op(1, 0, 8'h10); op(1, 0, 8'hF0); op(1, 0, 8'h33); op(1, 0, 8'h81);
        run_sort(1'b0, "R8 descending partial", lat);
        chk("R9 count kept", int'(count_o), 4);
        drain("R8 descending order");

        op(1, 0, 8'h00); op(1, 0, 8'hC3); op(1, 0, 8'hC3);
        op(1, 0, 8'h01); op(1, 0, 8'hFE); op(1, 0, 8'h7F);
        run_sort(1'b0, "R8 descending full", lat);
        drain("R8 descending dup order");

        op(1, 0, 8'h5A);
        run_sort(1'b1, "R10 one word", lat);
        chk("R10 one word latency", lat, 0);
        chk("R10 one word kept", int'(top_o), 8'h5A);
        drain("R10 one word drain");

        run_sort(1'b1, "R10 empty", lat);
        chk("R10 empty latency", lat, 0);
        chk("R10 empty flag", int'(empty_o), 1);

        finish_run();
    end

endmodule